// File: doc/BRIEF.md
# Low-Power Mode Sequencer for an 8-bit Core

This block decides when a small 8-bit processor core and its surroundings are clocked. Software asks for a low-power state by writing a control register. The block then gates the clock enables for the CPU, the general peripherals and the analog-to-digital converter. It also drops the oscillator enable when the deepest state is requested. The control register carries an idle request bit, a power-down request bit, a quiet request bit and two general-purpose software flags.

Each state has its own exit rule. Idle and quiet end on any enabled interrupt request. Power-down ends only on a low level on an external interrupt pin whose enable is set. Before the CPU clock is released, the oscillator is given a stabilization interval. If the wake level goes away during that interval, the core falls back into power-down. A hardware reset ends every state. While the CPU is stopped, the block drives the address-latch and program-fetch strobes high and freezes the port outputs.

Top module: `pwr_mode_ctl`

## Requirements
- R1: In reset (rst_n low at a clock edge), and on the cycle after it, mode_o is 0 (active), reg_rdata is 0, all four enables are 1, and clk_mode equals cfg_clk_mode.
- R2: A write with reg_wdata bit 0 set (and bit 1 clear) while active puts the block in idle (mode_o = 1) after that edge. In idle, cpu_clk_en is 0 and per_clk_en, adc_clk_en and osc_en are 1.
- R3: In idle, irq_pend high at an edge returns the block to active after that edge, and reg_rdata bit 0 reads 0.
- R4: A reset from any state (idle, quiet, power-down, oscillator wait) returns mode_o to 0, clears reg_rdata, and reloads clk_mode from cfg_clk_mode.
- R5: While cpu_clk_en is 0, ale_out and psen_out are 1, and port_out keeps the port_in value captured at the last active edge.
- R6: A write with reg_wdata bit 1 set enters power-down (mode_o = 3) even when bit 0 is also set. In power-down, all four enables are 0.
- R7: In power-down, irq_pend and low levels on external pins whose ext_int_en bit is 0 do not change mode_o.
- R8: A low level on an enabled external pin moves power-down to oscillator wait (mode_o = 4), where only osc_en is 1. After STAB_CYC edges in oscillator wait with the level held, the block is active, and reg_rdata bits 0 and 1 read 0.
- R9: If the enabled wake level disappears during oscillator wait, the block returns to power-down (mode_o = 3).
- R10: A wake from power-down by external pin leaves the flag bits and clk_mode unchanged.
- R11: A write with only reg_wdata bit 4 of the request bits set enters quiet (mode_o = 2), where only adc_clk_en and osc_en are 1. irq_pend returns the block to active, and bit 4 reads 0.
- R12: Flag bits 2 and 3 of the register read back as written and are not altered by entering or leaving idle, quiet or power-down.
- R13: reg_wr is ignored while the block is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock of the controller |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data for the control register |
| reg_rdata | output | 8 | Control register contents |
| irq_pend | input | 1 | Some enabled interrupt is requesting service |
| ext_int_n | input | NUM_EXT | Level-sensitive external interrupt pins, active low |
| ext_int_en | input | NUM_EXT | Per-pin enable of the external interrupts |
| cfg_clk_mode | input | 2 | Clock mode loaded at reset |
| clk_mode | output | 2 | Clock mode in use |
| mode_o | output | 3 | Current state: 0 active, 1 idle, 2 quiet, 3 power-down, 4 oscillator wait |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_in | input | 1 | Address-latch strobe from the core |
| psen_in | input | 1 | Program-fetch strobe from the core |
| ale_out | output | 1 | Address-latch strobe to the pins |
| psen_out | output | 1 | Program-fetch strobe to the pins |
| port_in | input | PORT_W | Port values from the core |
| port_out | output | PORT_W | Port values to the pins |

## Verification
The properties assume that reg_wr is only meaningful while the core runs. They also assume that cfg_clk_mode is steady around reset, and that irq_pend and the external pins change only between clock edges. The bench drives every input at the falling edge. It holds the wake pin through the whole stabilization interval unless the test deliberately releases it early. It also raises reg_wr in a stopped state only to show that the write is dropped.

// File: rtl/pmc_pkg.sv
// Package: shared state encoding and control register bit positions for the
// low-power mode sequencer. Assumes an 8-bit control register.
package pmc_pkg;
    typedef enum logic [2:0] {
        PM_ACTIVE = 3'd0,
        PM_IDLE   = 3'd1,
        PM_QUIET  = 3'd2,
        PM_PDOWN  = 3'd3,
        PM_OSCW   = 3'd4
    } pm_mode_e;

    localparam int REG_W    = 8;
    localparam int B_IDLE   = 0;
    localparam int B_PDOWN  = 1;
    localparam int B_FLAG0  = 2;
    localparam int B_FLAG1  = 3;
    localparam int B_QUIET  = 4;

    typedef struct packed {
        logic quiet;
        logic flag1;
        logic flag0;
        logic pdown;
        logic idle;
    } pcr_t;
endpackage

// File: rtl/pmc_ctrl_reg.sv
// Module: control register. It holds the request bits and the two software
// flags, plus the clock mode loaded at reset. Assumes wr_ok is asserted only
// while the core runs, and that the clear pulses come from the mode machine.
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [REG_W-1:0] wdata,
    input  logic             clr_idle,
    input  logic             clr_pdown,
    input  logic             clr_quiet,
    input  logic [1:0]       cfg_clk_mode,
    output pcr_t             pcr,
    output logic [1:0]       clk_mode,
    output logic [REG_W-1:0] rdata
);
    // Purpose: update the register from software writes and hardware clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcr <= '0;
        end else if (wr_ok) begin
            pcr.idle  <= wdata[B_IDLE];
            pcr.pdown <= wdata[B_PDOWN];
            pcr.flag0 <= wdata[B_FLAG0];
            pcr.flag1 <= wdata[B_FLAG1];
            pcr.quiet <= wdata[B_QUIET];
        end else begin
            if (clr_idle)  pcr.idle  <= 1'b0;
            if (clr_pdown) pcr.pdown <= 1'b0;
            if (clr_quiet) pcr.quiet <= 1'b0;
        end
    end

    // Purpose: latch the clock mode chosen by configuration at reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_mode <= cfg_clk_mode;
    end

    // Purpose: assemble the read view with unused bits at zero.
    always_comb begin
        rdata          = '0;
        rdata[B_IDLE]  = pcr.idle;
        rdata[B_PDOWN] = pcr.pdown;
        rdata[B_FLAG0] = pcr.flag0;
        rdata[B_FLAG1] = pcr.flag1;
        rdata[B_QUIET] = pcr.quiet;
    end
endmodule

// File: rtl/pmc_stab_timer.sv
// Module: oscillator stabilization timer. It counts edges while run is high
// and flags the last edge of the interval. Assumes STAB_CYC >= 2.
module pmc_stab_timer #(
    parameter int STAB_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(STAB_CYC);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

    logic [CW-1:0] cnt;

    // Purpose: advance while running, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/pmc_mode_fsm.sv
// Module: mode state machine. It picks the low-power state from the register
// write and handles each state's exit rule. Power-down has priority over
// idle, and idle over quiet. Assumes wr_ok only in the active state.
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int STAB_CYC = 1024
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_ok,
    input  logic     req_idle,
    input  logic     req_pdown,
    input  logic     req_quiet,
    input  logic     irq_pend,
    input  logic     ext_wake,
    output pm_mode_e mode,
    output logic     clr_idle,
    output logic     clr_pdown,
    output logic     clr_quiet
);
    pm_mode_e nxt;
    logic     stab_done;

    pmc_stab_timer #(.STAB_CYC(STAB_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode == PM_OSCW && ext_wake),
        .done  (stab_done)
    );

    // Purpose: compute the next state and the hardware clear pulses.
    always_comb begin
        nxt       = mode;
        clr_idle  = 1'b0;
        clr_pdown = 1'b0;
        clr_quiet = 1'b0;
        unique case (mode)
            PM_ACTIVE: begin
                if (wr_ok) begin
                    if (req_pdown)      nxt = PM_PDOWN;
                    else if (req_idle)  nxt = PM_IDLE;
                    else if (req_quiet) nxt = PM_QUIET;
                end
            end
            PM_IDLE: begin
                if (irq_pend) begin
                    nxt      = PM_ACTIVE;
                    clr_idle = 1'b1;
                end
            end
            PM_QUIET: begin
                if (irq_pend) begin
                    nxt       = PM_ACTIVE;
                    clr_quiet = 1'b1;
                end
            end
            PM_PDOWN: begin
                if (ext_wake) nxt = PM_OSCW;
            end
            PM_OSCW: begin
                if (!ext_wake) begin
                    nxt = PM_PDOWN;
                end else if (stab_done) begin
                    nxt       = PM_ACTIVE;
                    clr_pdown = 1'b1;
                    clr_idle  = 1'b1;
                    clr_quiet = 1'b1;
                end
            end
            default: nxt = PM_ACTIVE;
        endcase
    end

    // Purpose: hold the state; reset always lands in active.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= PM_ACTIVE;
        else        mode <= nxt;
    end
endmodule

// File: rtl/pmc_clk_gate.sv
// Module: clock enables and pin holding. It decodes the state into the four
// enables, forces the bus strobes high and freezes the ports while the CPU
// is stopped. Assumes port_in is valid on active edges.
module pmc_clk_gate
    import pmc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pm_mode_e          mode,
    input  logic              ale_in,
    input  logic              psen_in,
    input  logic [PORT_W-1:0] port_in,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              adc_clk_en,
    output logic              osc_en,
    output logic              ale_out,
    output logic              psen_out,
    output logic [PORT_W-1:0] port_out
);
    logic [PORT_W-1:0] port_hold;

    // Purpose: map the state to the clock and oscillator enables.
    always_comb begin
        cpu_clk_en = (mode == PM_ACTIVE);
        per_clk_en = (mode == PM_ACTIVE) || (mode == PM_IDLE);
        adc_clk_en = per_clk_en || (mode == PM_QUIET);
        osc_en     = (mode != PM_PDOWN);
    end

    // Purpose: track the port values on every edge while the CPU runs.
    always_ff @(posedge clk) begin
        if (!rst_n)          port_hold <= '0;
        else if (cpu_clk_en) port_hold <= port_in;
    end

    // Purpose: pass or hold the pins depending on whether the CPU runs.
    always_comb begin
        ale_out  = cpu_clk_en ? ale_in  : 1'b1;
        psen_out = cpu_clk_en ? psen_in : 1'b1;
        port_out = cpu_clk_en ? port_in : port_hold;
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
// Module: top of the low-power mode sequencer. It joins the control
// register, the mode machine and the gating. The clock is the oscillator
// and is modelled as running even in power-down, so the timer can count.
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int STAB_CYC = 1024,
    parameter int NUM_EXT  = 2,
    parameter int PORT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               irq_pend,
    input  logic [NUM_EXT-1:0] ext_int_n,
    input  logic [NUM_EXT-1:0] ext_int_en,
    input  logic [1:0]         cfg_clk_mode,
    output logic [1:0]         clk_mode,
    output logic [2:0]         mode_o,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               adc_clk_en,
    output logic               osc_en,
    input  logic               ale_in,
    input  logic               psen_in,
    output logic               ale_out,
    output logic               psen_out,
    input  logic [PORT_W-1:0]  port_in,
    output logic [PORT_W-1:0]  port_out
);
    pm_mode_e mode;
    pcr_t     pcr;
    logic     wr_ok, ext_wake;
    logic     clr_idle, clr_pdown, clr_quiet;

    // Purpose: qualify writes and fold the enabled low-level pins together.
    assign wr_ok    = reg_wr && (mode == PM_ACTIVE);
    assign ext_wake = |(~ext_int_n & ext_int_en);
    assign mode_o   = mode;

    pmc_ctrl_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ok        (wr_ok),
        .wdata        (reg_wdata),
        .clr_idle     (clr_idle),
        .clr_pdown    (clr_pdown),
        .clr_quiet    (clr_quiet),
        .cfg_clk_mode (cfg_clk_mode),
        .pcr          (pcr),
        .clk_mode     (clk_mode),
        .rdata        (reg_rdata)
    );

    pmc_mode_fsm #(.STAB_CYC(STAB_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .req_idle  (reg_wdata[B_IDLE]),
        .req_pdown (reg_wdata[B_PDOWN]),
        .req_quiet (reg_wdata[B_QUIET]),
        .irq_pend  (irq_pend),
        .ext_wake  (ext_wake),
        .mode      (mode),
        .clr_idle  (clr_idle),
        .clr_pdown (clr_pdown),
        .clr_quiet (clr_quiet)
    );

    pmc_clk_gate #(.PORT_W(PORT_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .ale_in     (ale_in),
        .psen_in    (psen_in),
        .port_in    (port_in),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .adc_clk_en (adc_clk_en),
        .osc_en     (osc_en),
        .ale_out    (ale_out),
        .psen_out   (psen_out),
        .port_out   (port_out)
    );
endmodule

// File: rtl/pmc_checks.sv
// Module: property checker bound to the sequencer top. It observes ports
// only; the stabilization window is measured with a local counter.
module pmc_checks #(
    parameter int STAB_CYC = 1024,
    parameter int NUM_EXT  = 2,
    parameter int PORT_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         reg_rdata,
    input logic               irq_pend,
    input logic [NUM_EXT-1:0] ext_int_n,
    input logic [NUM_EXT-1:0] ext_int_en,
    input logic [2:0]         mode_o,
    input logic               cpu_clk_en,
    input logic               per_clk_en,
    input logic               adc_clk_en,
    input logic               osc_en,
    input logic               ale_out,
    input logic               psen_out,
    input logic [PORT_W-1:0]  port_out
);
    logic wake;
    int   wcnt;
    assign wake = |(~ext_int_n & ext_int_en);

    // Purpose: count edges spent in oscillator wait.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_o != 3'd4) wcnt <= 0;
        else                          wcnt <= wcnt + 1;
    end

    assert_idle_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd1 |-> !cpu_clk_en && per_clk_en && adc_clk_en && osc_en);
    assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd1 && irq_pend |=> mode_o == 3'd0 && !reg_rdata[0]);
    assert_strobes_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> ale_out && psen_out);
    assert_ports_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en && $past(!cpu_clk_en) |-> $stable(port_out));
    assert_pdown_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd3 |-> !osc_en && !cpu_clk_en && !per_clk_en && !adc_clk_en);
    assert_pdown_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd3 && !wake |=> mode_o == 3'd3);
    assert_no_early_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd4 && wcnt < STAB_CYC - 1 |=> mode_o != 3'd0);
    assert_wait_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd4 && !wake |=> mode_o == 3'd3);
    assert_quiet_gating_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd2 |-> adc_clk_en && !per_clk_en && !cpu_clk_en);
    assert_flags_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 3'd0 && $past(mode_o) != 3'd0 |-> $stable(reg_rdata[3:2]));
endmodule

bind pwr_mode_ctl pmc_checks #(
    .STAB_CYC (STAB_CYC),
    .NUM_EXT  (NUM_EXT),
    .PORT_W   (PORT_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .irq_pend   (irq_pend),
    .ext_int_n  (ext_int_n),
    .ext_int_en (ext_int_en),
    .mode_o     (mode_o),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .adc_clk_en (adc_clk_en),
    .osc_en     (osc_en),
    .ale_out    (ale_out),
    .psen_out   (psen_out),
    .port_out   (port_out)
);

// File: tb/test_pwr_mode_ctl.sv
// Directed bench: one task per scenario; drive and sample at falling edges.
module test_pwr_mode_ctl;
    localparam int STAB = 40;
    localparam int PW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq_pend = 1'b0;
    logic [1:0]    ext_int_n = 2'b11;
    logic [1:0]    ext_int_en = 2'b00;
    logic [1:0]    cfg_clk_mode = 2'b10;
    logic [1:0]    clk_mode;
    logic [2:0]    mode_o;
    logic          cpu_clk_en, per_clk_en, adc_clk_en, osc_en;
    logic          ale_in = 1'b0, psen_in = 1'b0, ale_out, psen_out;
    logic [PW-1:0] port_in = '0, port_out;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctl #(.STAB_CYC(STAB), .NUM_EXT(2), .PORT_W(PW)) i_pwr_mode_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pend(irq_pend), .ext_int_n(ext_int_n),
        .ext_int_en(ext_int_en), .cfg_clk_mode(cfg_clk_mode), .clk_mode(clk_mode),
        .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .adc_clk_en(adc_clk_en), .osc_en(osc_en), .ale_in(ale_in), .psen_in(psen_in),
        .ale_out(ale_out), .psen_out(psen_out), .port_in(port_in), .port_out(port_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // enables packed as {cpu, per, adc, osc}
    function automatic logic [3:0] ens();
        return {cpu_clk_en, per_clk_en, adc_clk_en, osc_en};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        cfg_clk_mode = 2'b10;
        do_reset();
        chk("R1", "mode", mode_o, 0);
        chk("R1", "rdata", reg_rdata, 0);
        chk("R1", "enables", ens(), 4'b1111);
        chk("R1", "clk_mode", clk_mode, 2'b10);
    endtask

    task automatic t_idle_irq();
        port_in = 8'hA5; ale_in = 1'b0; psen_in = 1'b0;
        wr(8'h01);
        chk("R2", "idle mode", mode_o, 1);
        chk("R2", "idle enables", ens(), 4'b0111);
        port_in = 8'h3C;
        step(3);
        chk("R5", "port held", port_out, 8'hA5);
        chk("R5", "strobes", {ale_out, psen_out}, 2'b11);
        irq_pend = 1'b1;
        step(1);
        irq_pend = 1'b0;
        chk("R3", "idle exit mode", mode_o, 0);
        chk("R3", "bit0 cleared", reg_rdata[0], 0);
        chk("R5", "port passes again", port_out, 8'h3C);
    endtask

    task automatic t_flags_and_ignored_write();
        wr(8'h0C);
        chk("R12", "flags readback", reg_rdata, 8'h0C);
        wr(8'h0D);
        chk("R12", "flags kept in idle", reg_rdata[3:2], 2'b11);
        reg_wr = 1'b1; reg_wdata = 8'h02;
        step(1);
        reg_wr = 1'b0; reg_wdata = '0;
        chk("R13", "write in idle ignored mode", mode_o, 1);
        chk("R13", "write in idle ignored reg", reg_rdata, 8'h0D);
        irq_pend = 1'b1; step(1); irq_pend = 1'b0;
        chk("R12", "flags after idle exit", reg_rdata, 8'h0C);
    endtask

    task automatic t_quiet();
        wr(8'h10);
        chk("R11", "quiet mode", mode_o, 2);
        chk("R11", "quiet enables", ens(), 4'b0011);
        irq_pend = 1'b1; step(1); irq_pend = 1'b0;
        chk("R11", "quiet exit", mode_o, 0);
        chk("R11", "bit4 cleared", reg_rdata[4], 0);
    endtask

    task automatic t_pdown_wake();
        wr(8'h0B);
        chk("R6", "pd wins over idle", mode_o, 3);
        chk("R6", "pd enables", ens(), 4'b0000);
        ext_int_en = 2'b01;
        irq_pend = 1'b1; ext_int_n = 2'b01;
        step(3);
        irq_pend = 1'b0; ext_int_n = 2'b11;
        chk("R7", "irq and disabled pin ignored", mode_o, 3);
        ext_int_n = 2'b10;
        step(1);
        chk("R8", "osc wait mode", mode_o, 4);
        chk("R8", "osc wait enables", ens(), 4'b0001);
        step(STAB - 1);
        chk("R8", "still waiting", mode_o, 4);
        step(1);
        ext_int_n = 2'b11;
        chk("R8", "active after interval", mode_o, 0);
        chk("R8", "bits 0,1 cleared", reg_rdata[1:0], 2'b00);
        chk("R10", "flags preserved", reg_rdata[3:2], 2'b10);
        chk("R10", "clk_mode preserved", clk_mode, 2'b10);
    endtask

    task automatic t_early_release();
        wr(8'h02);
        ext_int_en = 2'b10; ext_int_n = 2'b01;
        step(1);
        chk("R9", "wait entered", mode_o, 4);
        step(STAB / 2);
        ext_int_n = 2'b11;
        step(1);
        chk("R9", "back to pd", mode_o, 3);
        chk("R9", "osc off again", osc_en, 0);
    endtask

    task automatic t_reset_exit();
        cfg_clk_mode = 2'b01;
        do_reset();
        chk("R4", "reset from pd mode", mode_o, 0);
        chk("R4", "reset clk_mode reload", clk_mode, 2'b01);
        wr(8'h1C);
        chk("R4", "quiet before reset", mode_o, 2);
        do_reset();
        chk("R4", "reset from quiet", mode_o, 0);
        chk("R4", "reset clears reg", reg_rdata, 0);
        wr(8'h01);
        do_reset();
        chk("R4", "reset from idle", mode_o, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_idle_irq();
                t_flags_and_ignored_write();
                t_quiet();
                t_pdown_wake();
                t_early_release();
                t_reset_exit();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule